// File: doc/BRIEF.md
# Packet-Gated Receive Byte Queue

This block sits between a serial receiver's byte output and a processor read port. It stores received bytes in a small first-in first-out queue. Software cannot use the queue as an ordinary streaming buffer. A programmable packet length decides when the stored bytes become readable. The block counts the bytes of the current packet. It raises a packet-end flag when the programmed number of bytes has arrived, and a queue-full flag whenever the queue holds its full four bytes. Either event drives the active-low interrupt and locks the queue.

While the queue is locked, the processor reads the stored bytes out in arrival order. The receiver is told to hold off. Any byte the receiver delivers anyway is dropped and recorded as an overrun. Reading the last stored byte clears every flag, releases the interrupt and reopens the queue for the next bytes.

Top module: `pkt_rx_fifo`

## Requirements
- R1: The queue holds at most DEPTH (default 4) bytes and returns them in the order they were accepted.
- R2: With a packet length of 1 to 3, the packet-end flag (status bit 0) sets after that many bytes have been accepted, and irq_n_o goes low.
- R3: With a packet length of 4 or more, the queue-full flag (status bit 1) sets each time the fourth stored byte is accepted, and irq_n_o goes low.
- R4: The final byte of a longer packet sets status bit 0. When the length is a multiple of four, that byte sets bits 0 and 1 in the same cycle.
- R5: The status flags, irq_n_o and rx_hold_o are registered. They change in the cycle after the clock edge that samples the causing strobe. rx_hold_o is high and irq_n_o is low exactly while bit 0 or bit 1 is set.
- R6: A byte strobed while rx_hold_o is high is discarded and sets the overrun flag (status bit 2).
- R7: rd_i while rx_hold_o is low is ignored. rd_data_o keeps its value, and no stored byte is consumed.
- R8: rd_i while rx_hold_o is high presents the oldest stored byte on rd_data_o after the next clock edge.
- R9: Reading the last stored byte clears status bits 0, 1 and 2, raises irq_n_o and lowers rx_hold_o. This clear wins over an overrun in the same cycle.
- R10: The packet byte count restarts after each packet end, so the next accepted byte is the first of a new packet.
- R11: Synchronous reset empties the queue, clears all status bits and rd_data_o, drives irq_n_o high and rx_hold_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | DATA_W | Received byte |
| blk_len_i | input | LEN_W | Packet length in bytes |
| rd_i | input | 1 | Processor read strobe |
| rd_data_o | output | DATA_W | Byte read from the queue |
| stat_o | output | 3 | bit0 packet end, bit1 queue full, bit2 overrun |
| irq_n_o | output | 1 | Active-low interrupt |
| rx_hold_o | output | 1 | Tells the receiver the queue is locked |

## Verification
The bench checks a length that is an exact multiple of four. A design that sequenced the flags instead of setting them together would show queue-full without packet-end on the final byte. It checks a six-byte packet, where a counter tied to occupancy rather than packet position would miss the packet-end on byte six. It also drops bytes and issues reads while the queue is unlocked. A leaky lock would then surface as shifted read data or a missing overrun. Partial drains check that the lock holds until the very last byte leaves.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
  localparam int ST_W   = 3;
  localparam int ST_PE  = 0;
  localparam int ST_BF  = 1;
  localparam int ST_OV  = 2;
endpackage

// File: rtl/pkt_fifo_mem.sv
module pkt_fifo_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pkt_fifo_ptrs.sv
module pkt_fifo_ptrs #(
  parameter int DEPTH = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic [AW-1:0]    wptr,
  output logic [AW-1:0]    rptr,
  output logic [OCC_W-1:0] occ
);
  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      if (push && !pop)      occ <= occ + OCC_W'(1);
      else if (pop && !push) occ <= occ - OCC_W'(1);
    end
  end

  // R1
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(DEPTH));
endmodule

// File: rtl/pkt_len_ctr.sv
module pkt_len_ctr #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic [LEN_W-1:0] len_i,
  output logic             hit_o
);
  logic [LEN_W-1:0] cnt;

  assign hit_o = inc && ((cnt + LEN_W'(1)) == len_i);

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (hit_o) cnt <= '0;
    else if (inc)   cnt <= cnt + LEN_W'(1);
  end
endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo
  import pkt_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic [LEN_W-1:0]  blk_len_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ST_W-1:0]   stat_o,
  output logic              irq_n_o,
  output logic              rx_hold_o
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [AW-1:0]    wptr, rptr;
  logic [OCC_W-1:0] occ;
  logic             wr_en, rd_en, last_rd, hit;
  logic             pe_q, bf_q, ov_q, hold_q, irq_n_q;
  logic             pe_d, bf_d, ov_d;

  assign wr_en   = byte_vld_i && !hold_q;
  assign rd_en   = rd_i && hold_q && (occ != '0);
  assign last_rd = rd_en && (occ == OCC_W'(1));

  pkt_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .push(wr_en), .pop(rd_en),
    .wptr(wptr), .rptr(rptr), .occ(occ)
  );

  pkt_fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wptr), .wdata(byte_i),
    .re(rd_en), .raddr(rptr), .rdata(rd_data_o)
  );

  pkt_len_ctr #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst(rst), .inc(wr_en), .len_i(blk_len_i), .hit_o(hit)
  );

  always_comb begin
    pe_d = pe_q;
    bf_d = bf_q;
    ov_d = ov_q;
    if (wr_en && hit) pe_d = 1'b1;
    if (wr_en && occ == OCC_W'(DEPTH - 1)) bf_d = 1'b1;
    if (byte_vld_i && hold_q) ov_d = 1'b1;
    if (last_rd) begin
      pe_d = 1'b0;
      bf_d = 1'b0;
      ov_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pe_q    <= 1'b0;
      bf_q    <= 1'b0;
      ov_q    <= 1'b0;
      hold_q  <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      pe_q    <= pe_d;
      bf_q    <= bf_d;
      ov_q    <= ov_d;
      hold_q  <= pe_d || bf_d;
      irq_n_q <= !(pe_d || bf_d);
    end
  end

  assign stat_o[ST_PE] = pe_q;
  assign stat_o[ST_BF] = bf_q;
  assign stat_o[ST_OV] = ov_q;
  assign irq_n_o       = irq_n_q;
  assign rx_hold_o     = hold_q;

  // R6
  drop_when_held_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_hold_o && byte_vld_i && !last_rd) |=> (stat_o[ST_OV] && $stable(occ)));

  // R7
  rd_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!rx_hold_o && rd_i) |=> $stable(rd_data_o));

  // R9
  drain_release_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_hold_o && rd_i && occ == OCC_W'(1)) |=> (irq_n_o && !rx_hold_o && stat_o == '0));

  // R3
  full_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_o[ST_BF]) |-> (occ == OCC_W'(DEPTH)));
endmodule

// File: tb/tb_pkt_rx_fifo.sv
module tb_pkt_rx_fifo;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic [7:0] blk_len_i = 8'd1;
  logic       rd_i = 1'b0;
  logic [7:0] rd_data_o;
  logic [2:0] stat_o;
  logic       irq_n_o, rx_hold_o;

  always #4 clk = ~clk;

  pkt_rx_fifo dut (
    .clk(clk), .rst(rst), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .blk_len_i(blk_len_i), .rd_i(rd_i), .rd_data_o(rd_data_o),
    .stat_o(stat_o), .irq_n_o(irq_n_o), .rx_hold_o(rx_hold_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0] q[$];
  bit         m_pe, m_bf, m_ov;
  int         m_pc;
  logic [7:0] m_rd;

  task automatic compare(input string req);
    logic [2:0] es;
    es = {m_ov, m_bf, m_pe};
    n_cmp++;
    if (rd_data_o !== m_rd || stat_o !== es || irq_n_o !== !(m_pe | m_bf) ||
        rx_hold_o !== (m_pe | m_bf)) begin
      n_bad++;
      $display("FAIL %s: got data=%h stat=%b irq_n=%b hold=%b, exp data=%h stat=%b irq_n=%b hold=%b",
               req, rd_data_o, stat_o, irq_n_o, rx_hold_o, m_rd, es, !(m_pe | m_bf), m_pe | m_bf);
    end
  endtask

  task automatic step(input bit vld, input logic [7:0] b, input bit rd, input string req);
    bit locked;
    byte_vld_i = vld; byte_i = b; rd_i = rd;
    locked = m_pe | m_bf;
    if (vld) begin
      if (locked) m_ov = 1;
      else begin
        q.push_back(b);
        m_pc++;
        if (m_pc == int'(blk_len_i)) begin m_pe = 1; m_pc = 0; end
        if (q.size() == 4) m_bf = 1;
      end
    end
    if (rd && locked && q.size() > 0) begin
      m_rd = q.pop_front();
      if (q.size() == 0) begin m_pe = 0; m_bf = 0; m_ov = 0; end
    end
    @(posedge clk);
    @(negedge clk);
    byte_vld_i = 0; rd_i = 0;
    compare(req);
  endtask

  task automatic send(input logic [7:0] b, input string req);
    step(1, b, 0, req);
  endtask

  task automatic drain(input int n, input string req);
    for (int i = 0; i < n; i++) step(0, 8'h00, 1, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    m_rd = '0;
    compare("R11 reset");

    // R7: reads before lock are ignored
    blk_len_i = 8'd3;
    send(8'hA1, "R7");
    step(0, 8'h00, 1, "R7 early read");
    send(8'hA2, "R7");
    step(0, 8'h00, 1, "R7 early read");
    send(8'hA3, "R2 len3 end");
    // R6: byte while locked dropped
    send(8'hEE, "R6 overrun");
    drain(1, "R8 read oldest");
    send(8'hEF, "R6 overrun again");
    drain(2, "R9 drain clears");

    // R2: length 2
    blk_len_i = 8'd2;
    send(8'h11, "R2"); send(8'h12, "R2 len2 end");
    step(0, 8'h00, 1, "R8");
    step(1, 8'h55, 1, "R9 clear wins over overrun");

    // R10: length 1 back to back
    blk_len_i = 8'd1;
    for (int k = 0; k < 3; k++) begin
      send(8'h20 + 8'(k), "R10 len1");
      drain(1, "R10 drain");
    end

    // R3 / R4 / R10: length 6
    blk_len_i = 8'd6;
    for (int k = 0; k < 4; k++) send(8'h30 + 8'(k), "R3 full");
    send(8'h99, "R6 while full");
    drain(2, "R1 order");
    step(0, 8'h00, 0, "R9 partial hold");
    drain(2, "R1 order");
    send(8'h34, "R10 continue");
    send(8'h35, "R4 last byte end");
    drain(2, "R9");

    // R4: length 8, multiple of four
    blk_len_i = 8'd8;
    for (int k = 0; k < 4; k++) send(8'h40 + 8'(k), "R3");
    drain(4, "R1");
    for (int k = 4; k < 8; k++) send(8'h40 + 8'(k), "R4 both flags");
    drain(4, "R9");

    // R5: idle cycles keep state
    step(0, 8'h00, 0, "R5 idle");

    rst = 1;
    q.delete(); m_pe = 0; m_bf = 0; m_ov = 0; m_pc = 0; m_rd = '0;
    @(posedge clk); @(negedge clk);
    rst = 0;
    compare("R11 reset again");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule